// File: doc/BRIEF.md
# Reconfigurable Region Freeze Controller

This block sits between a software-visible register bus and one reconfigurable logic region. It runs the sequence that isolates the region before its logic is replaced and brings the region back into service afterwards. Software writes request bits into a control word. The block turns each pending request into a level request to the region and waits for the region to acknowledge it. When the acknowledge arrives, the block sets a status bit. The request bit then clears itself, and the status bit follows one cycle later.

A freeze request is answered by `stop_ack`. Its completion raises the `freeze` output, which stays high until a later unfreeze request is answered by `start_ack`. A separate level bit holds the region in reset for as long as software keeps it set. Each freeze bridge has its own illegal-access input. A pulse on that input sets a sticky flag, and software clears the flag by writing 1 to it. Any flag that is set drives the interrupt output.

The register bus is 32 bits wide and word-addressed, with four words. Read data is registered, so it appears one cycle after the read strobe is sampled.

Top module: `rrf_freeze_ctrl`

## Requirements
- R1: Word 0 is status, word 1 is control, word 2 is the illegal-access flags and word 3 is a constant that always reads 0xAD000003. `bus_rdata` takes the addressed word on the clock edge that samples `bus_rd` high, and reads as 0 after an edge where `bus_rd` is low.
- R2: After reset, every register reads 0 except word 3. The outputs `freeze`, `region_reset`, `irq`, `stop_req` and `start_req` are all low.
- R3: Writing 1 to control bit 0 (freeze request) makes `stop_req` high from the next cycle. An edge that samples `stop_ack` high while the freeze request is pending sets status bit 0 and `freeze` on that same edge.
- R4: On the edge after a status bit is seen high, the matching request bit clears. On the edge after a request bit is low, the matching status bit clears. This applies to both freeze (control bit 0 and status bit 0) and unfreeze (control bit 2 and status bit 1).
- R5: Writing 1 to control bit 2 (unfreeze request) drives `start_req`. An edge that samples `start_ack` high while the unfreeze request is pending sets status bit 1 and drops `freeze`.
- R6: Writing 0 to a pending request bit abandons it. The request output drops, no status bit sets, and `freeze` keeps its value.
- R7: A control write with both bit 0 and bit 2 set leaves both request bits unchanged and starts no handshake. Bit 1 of that write still takes effect.
- R8: Control bit 1 is a level bit that drives `region_reset` directly from its register.
- R9: A high `illegal_in[i]` sets flag bit i of word 2. Writing 1 to bit i clears it. When a set and a clear hit the same bit on the same edge, the set wins. `irq` is high whenever any flag is set.
- R10: `freeze` stays high after the freeze request and status self-clear, until an unfreeze handshake completes.
- R11: `stop_ack` or `start_ack` has no effect while no matching request is pending.
- R12: Control bits 31:3, status bits 31:2 and the flag bits at N_BRIDGE and above always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| stop_req | output | 1 | Freeze request to the region |
| stop_ack | input | 1 | Region ready to be frozen |
| start_req | output | 1 | Unfreeze request to the region |
| start_ack | input | 1 | Region has started |
| freeze | output | 1 | Region interfaces held frozen |
| region_reset | output | 1 | Region held in reset |
| illegal_in | input | N_BRIDGE | Per-bridge illegal-access pulses |
| irq | output | 1 | Any illegal-access flag set |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- Read data appears on the edge that samples the strobe.
- Request outputs, `region_reset`, the flags and `irq` change on the edge that takes the write or pulse.
- Status and `freeze` change on the edge that samples the acknowledge.
- Each self-clear step follows one edge after the step before it.

The bench drives everything at falling edges and samples at falling edges. Each read is queued with its expected word when the strobe goes up, and the monitor compares it at the falling edge after the sampling edge. The reads that follow a handshake are placed so that they land in the single cycle where the status bit is expected high, and again after both self-clear steps have passed.

// File: rtl/rrf_pkg.sv
// Package: shared constants for the reconfigurable region freeze controller.
// Assumes a 32-bit data bus with four word addresses.
package rrf_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_STATUS  = 2'd0,
        RA_CTRL    = 2'd1,
        RA_ILLEGAL = 2'd2,
        RA_VERSION = 2'd3
    } reg_addr_e;

    localparam int CB_FREEZE   = 0;
    localparam int CB_RESET    = 1;
    localparam int CB_UNFREEZE = 2;

    localparam int SB_FREEZE   = 0;
    localparam int SB_UNFREEZE = 1;

    localparam logic [DATA_W-1:0] VERSION_WORD = 32'hAD00_0003;
endpackage

// File: rtl/rrf_req_chan.sv
// Module: one self-clearing request/acknowledge channel.
// A software write sets or clears the request. An acknowledge while the
// request is pending sets status. Status high clears the request on the next
// edge, and a low request clears status. Assumes the write takes precedence
// over the hardware clear on the same edge.
module rrf_req_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_val,
    input  logic ack,
    output logic req,
    output logic status,
    output logic done
);
    // Request bit: software write, else self-clear once status is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else if (wr_en) begin
            req <= wr_val;
        end else if (status) begin
            req <= 1'b0;
        end
    end

    // Status bit: set by acknowledge while requesting, cleared when request is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (!req) begin
            status <= 1'b0;
        end else if (ack) begin
            status <= 1'b1;
        end
    end

    // Completion pulse: the acknowledge that is about to set status.
    assign done = req & ack & ~status;
endmodule

// File: rtl/rrf_ctrl_decode.sv
// Module: write decode for the register bus.
// Splits a bus write into per-field write enables. A control write that
// asks for both freeze and unfreeze leaves both request fields alone.
// Assumes single-cycle write strobes.
module rrf_ctrl_decode
    import rrf_pkg::*;
#(
    parameter int N_BRIDGE = 4
) (
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 frz_wr_en,
    output logic                 frz_wr_val,
    output logic                 unf_wr_en,
    output logic                 unf_wr_val,
    output logic                 rst_wr_en,
    output logic                 rst_wr_val,
    output logic [N_BRIDGE-1:0]  ill_clr
);
    logic ctrl_hit;
    logic both_req;
    logic wdata_unused;

    assign wdata_unused = ^bus_wdata;

    // Field enables derived from address and data.
    always_comb begin
        ctrl_hit   = bus_wr && (bus_addr == RA_CTRL);
        both_req   = bus_wdata[CB_FREEZE] && bus_wdata[CB_UNFREEZE];
        frz_wr_en  = ctrl_hit && !both_req;
        unf_wr_en  = ctrl_hit && !both_req;
        rst_wr_en  = ctrl_hit;
        frz_wr_val = bus_wdata[CB_FREEZE];
        unf_wr_val = bus_wdata[CB_UNFREEZE];
        rst_wr_val = bus_wdata[CB_RESET];
        ill_clr    = (bus_wr && (bus_addr == RA_ILLEGAL)) ? bus_wdata[N_BRIDGE-1:0]
                                                          : '0;
    end
endmodule

// File: rtl/rrf_illegal_flags.sv
// Module: sticky per-bridge illegal-access flags, cleared by writing 1.
// A set and a clear on the same edge leave the flag set. The interrupt is
// the OR of all flags. Assumes the inputs are synchronous to clk.
module rrf_illegal_flags #(
    parameter int N_BRIDGE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_BRIDGE-1:0] hit,
    input  logic [N_BRIDGE-1:0] clr,
    output logic [N_BRIDGE-1:0] flags,
    output logic                irq
);
    for (genvar i = 0; i < N_BRIDGE; i++) begin : g_flag
        // One flag: hardware set has priority over software clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (hit[i]) begin
                flags[i] <= 1'b1;
            end else if (clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

    // Interrupt: any flag set.
    assign irq = |flags;
endmodule

// File: rtl/rrf_read_mux.sv
// Module: registered read path for the four register words.
// Returns the addressed word on the edge that samples the read strobe,
// and zero after edges without a strobe. Unused bits are zero-filled.
module rrf_read_mux
    import rrf_pkg::*;
#(
    parameter int N_BRIDGE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                frz_status,
    input  logic                unf_status,
    input  logic                frz_req,
    input  logic                rst_req,
    input  logic                unf_req,
    input  logic [N_BRIDGE-1:0] flags,
    output logic [DATA_W-1:0]   bus_rdata
);
    logic [DATA_W-1:0] word;

    // Word selection with zero padding.
    always_comb begin
        word = '0;
        case (bus_addr)
            RA_STATUS: begin
                word[SB_FREEZE]   = frz_status;
                word[SB_UNFREEZE] = unf_status;
            end
            RA_CTRL: begin
                word[CB_FREEZE]   = frz_req;
                word[CB_RESET]    = rst_req;
                word[CB_UNFREEZE] = unf_req;
            end
            RA_ILLEGAL: word[N_BRIDGE-1:0] = flags;
            default:    word = VERSION_WORD;
        endcase
    end

    // Output register: one cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_rd ? word : '0;
        end
    end
endmodule

// File: rtl/rrf_freeze_ctrl.sv
// Module: top of the reconfigurable region freeze controller.
// Ties the write decode, two request channels (freeze and unfreeze), the
// region reset bit, the frozen state, the illegal-access flags and the read
// path together. Assumes 1 <= N_BRIDGE <= 32 and a single clock domain.
module rrf_freeze_ctrl
    import rrf_pkg::*;
#(
    parameter int N_BRIDGE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                stop_req,
    input  logic                stop_ack,
    output logic                start_req,
    input  logic                start_ack,
    output logic                freeze,
    output logic                region_reset,
    input  logic [N_BRIDGE-1:0] illegal_in,
    output logic                irq
);
    logic                frz_wr_en, frz_wr_val, unf_wr_en, unf_wr_val;
    logic                rst_wr_en, rst_wr_val;
    logic [N_BRIDGE-1:0] ill_clr, flags;
    logic                frz_req, frz_status, frz_done;
    logic                unf_req, unf_status, unf_done;
    logic                rst_req;
    logic                frozen;

    rrf_ctrl_decode #(.N_BRIDGE(N_BRIDGE)) u_decode (
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .frz_wr_en  (frz_wr_en),
        .frz_wr_val (frz_wr_val),
        .unf_wr_en  (unf_wr_en),
        .unf_wr_val (unf_wr_val),
        .rst_wr_en  (rst_wr_en),
        .rst_wr_val (rst_wr_val),
        .ill_clr    (ill_clr)
    );

    rrf_req_chan u_freeze_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (frz_wr_en),
        .wr_val (frz_wr_val),
        .ack    (stop_ack),
        .req    (frz_req),
        .status (frz_status),
        .done   (frz_done)
    );

    rrf_req_chan u_unfreeze_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (unf_wr_en),
        .wr_val (unf_wr_val),
        .ack    (start_ack),
        .req    (unf_req),
        .status (unf_status),
        .done   (unf_done)
    );

    // Region reset bit: plain level written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else if (rst_wr_en) begin
            rst_req <= rst_wr_val;
        end
    end

    // Frozen state: entered on stop acknowledge, left on start acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frozen <= 1'b0;
        end else if (unf_done) begin
            frozen <= 1'b0;
        end else if (frz_done) begin
            frozen <= 1'b1;
        end
    end

    rrf_illegal_flags #(.N_BRIDGE(N_BRIDGE)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (illegal_in),
        .clr   (ill_clr),
        .flags (flags),
        .irq   (irq)
    );

    rrf_read_mux #(.N_BRIDGE(N_BRIDGE)) u_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .frz_status (frz_status),
        .unf_status (unf_status),
        .frz_req    (frz_req),
        .rst_req    (rst_req),
        .unf_req    (unf_req),
        .flags      (flags),
        .bus_rdata  (bus_rdata)
    );

    assign stop_req     = frz_req;
    assign start_req    = unf_req;
    assign freeze       = frozen;
    assign region_reset = rst_req;
endmodule

// File: rtl/rrf_checker.sv
// Module: protocol checker for rrf_freeze_ctrl, attached with bind.
// Observes the bus, the region handshake and the request/status state.
module rrf_checker #(
    parameter int N_BRIDGE = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [1:0]          bus_addr,
    input logic [31:0]         bus_wdata,
    input logic                stop_ack,
    input logic                start_ack,
    input logic [N_BRIDGE-1:0] illegal_in,
    input logic                frz_req,
    input logic                unf_req,
    input logic                frz_status,
    input logic                unf_status,
    input logic                freeze,
    input logic                irq,
    input logic                stop_req,
    input logic                start_req
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == 2'd1);

    a_r3_stop_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_req && stop_ack && !frz_status && !ctrl_wr) |=> (frz_status && freeze));

    a_r4_freeze_req_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_status && !ctrl_wr) |=> !frz_req);

    a_r4_freeze_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !frz_req |=> !frz_status);

    a_r4_unfreeze_req_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_status && !ctrl_wr) |=> !unf_req);

    a_r5_start_ack_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_req && start_ack && !unf_status && !ctrl_wr) |=> (unf_status && !freeze));

    a_r7_both_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[0] && bus_wdata[2] && !frz_status && !unf_status)
        |=> ($stable(frz_req) && $stable(unf_req)));

    a_r9_flag_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (|illegal_in) |=> irq);

    a_r10_unfreeze_only_by_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(freeze) |-> $past(unf_req && start_ack));

    a_r11_no_spurious_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_req && !freeze) |=> !freeze);

    a_r7_requests_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_req && start_req));
endmodule

bind rrf_freeze_ctrl rrf_checker #(.N_BRIDGE(N_BRIDGE)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .stop_ack   (stop_ack),
    .start_ack  (start_ack),
    .illegal_in (illegal_in),
    .frz_req    (frz_req),
    .unf_req    (unf_req),
    .frz_status (frz_status),
    .unf_status (unf_status),
    .freeze     (freeze),
    .irq        (irq),
    .stop_req   (stop_req),
    .start_req  (start_req)
);

// File: tb/tb_rrf_freeze_ctrl.sv
// Bench: scoreboard for rrf_freeze_ctrl. Read tasks queue expected words,
// a monitor compares them one edge later; port levels are checked directly.
module tb_rrf_freeze_ctrl;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          stop_req, start_req, freeze, region_reset, irq;
    logic          stop_ack = 1'b0;
    logic          start_ack = 1'b0;
    logic [NB-1:0] illegal_in = '0;

    int vectors = 0;
    int miscompares = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_pending = 1'b0;
    logic        finished = 1'b0;

    always #5 clk = ~clk;

    rrf_freeze_ctrl #(.N_BRIDGE(NB)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stop_req(stop_req), .stop_ack(stop_ack), .start_req(start_req),
        .start_ack(start_ack), .freeze(freeze), .region_reset(region_reset),
        .illegal_in(illegal_in), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: note read strobes at the edge, compare at the next falling edge.
    always @(posedge clk) rd_pending <= bus_rd;
    always @(negedge clk) begin
        if (rd_pending) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected read", bus_rdata, 32'hxxxx_xxxx);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R2 reset state
        chk("R2 freeze", {31'd0, freeze}, 0);
        chk("R2 region_reset", {31'd0, region_reset}, 0);
        chk("R2 irq", {31'd0, irq}, 0);
        chk("R2 stop_req", {31'd0, stop_req}, 0);
        chk("R2 start_req", {31'd0, start_req}, 0);
        rd(2'd0, 32'h0, "R2 status");
        rd(2'd1, 32'h0, "R2 ctrl");
        rd(2'd2, 32'h0, "R2 illegal");
        rd(2'd3, 32'hAD00_0003, "R1 version");

        // R11 acks with nothing pending
        stop_ack = 1'b1; start_ack = 1'b1;
        idle(3);
        stop_ack = 1'b0; start_ack = 1'b0;
        chk("R11 freeze", {31'd0, freeze}, 0);
        rd(2'd0, 32'h0, "R11 status");

        // R3 freeze handshake
        wr(2'd1, 32'h1);
        chk("R3 stop_req", {31'd0, stop_req}, 1);
        chk("R3 freeze before ack", {31'd0, freeze}, 0);
        rd(2'd1, 32'h1, "R3 ctrl pending");
        stop_ack = 1'b1;
        rd(2'd0, 32'h1, "R3 status set");
        chk("R3 freeze after ack", {31'd0, freeze}, 1);
        rd(2'd1, 32'h0, "R4 freeze_req cleared");
        rd(2'd0, 32'h0, "R4 freeze_status cleared");
        stop_ack = 1'b0;
        chk("R4 stop_req dropped", {31'd0, stop_req}, 0);
        idle(4);
        chk("R10 freeze held", {31'd0, freeze}, 1);

        // R5 unfreeze handshake
        wr(2'd1, 32'h4);
        chk("R5 start_req", {31'd0, start_req}, 1);
        chk("R10 freeze before start_ack", {31'd0, freeze}, 1);
        start_ack = 1'b1;
        rd(2'd0, 32'h2, "R5 status set");
        chk("R5 freeze dropped", {31'd0, freeze}, 0);
        rd(2'd1, 32'h0, "R4 unfreeze_req cleared");
        rd(2'd0, 32'h0, "R4 unfreeze_status cleared");
        start_ack = 1'b0;

        // R6 abort a pending freeze
        wr(2'd1, 32'h1);
        idle(3);
        wr(2'd1, 32'h0);
        chk("R6 stop_req dropped", {31'd0, stop_req}, 0);
        stop_ack = 1'b1;
        idle(2);
        stop_ack = 1'b0;
        chk("R6 freeze unchanged", {31'd0, freeze}, 0);
        rd(2'd0, 32'h0, "R6 status");

        // R7 both requests in one write
        wr(2'd1, 32'h5);
        chk("R7 no stop_req", {31'd0, stop_req}, 0);
        chk("R7 no start_req", {31'd0, start_req}, 0);
        rd(2'd1, 32'h0, "R7 ctrl idle");
        wr(2'd1, 32'h1);
        wr(2'd1, 32'h7);
        rd(2'd1, 32'h3, "R7 freeze kept, reset taken");
        wr(2'd1, 32'h0);

        // R8 region reset level
        wr(2'd1, 32'h2);
        chk("R8 region_reset high", {31'd0, region_reset}, 1);
        wr(2'd1, 32'h0);
        chk("R8 region_reset low", {31'd0, region_reset}, 0);

        // R12 reserved bits
        wr(2'd1, 32'hFFFF_FFFA);
        rd(2'd1, 32'h2, "R12 ctrl reserved");
        wr(2'd1, 32'h0);

        // R9 illegal-access flags
        @(negedge clk); illegal_in = 4'b0010;
        @(negedge clk); illegal_in = '0;
        chk("R9 irq set", {31'd0, irq}, 1);
        rd(2'd2, 32'h2, "R9 flag 1");
        @(negedge clk); illegal_in = 4'b1000;
        @(negedge clk); illegal_in = '0;
        rd(2'd2, 32'hA, "R9 flags 1 and 3");
        wr(2'd2, 32'h2);
        rd(2'd2, 32'h8, "R9 w1c flag 1");
        chk("R9 irq still set", {31'd0, irq}, 1);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, 32'h0, "R12 flags cleared, upper zero");
        chk("R9 irq cleared", {31'd0, irq}, 0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h1; illegal_in = 4'b0001;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; illegal_in = '0;
        rd(2'd2, 32'h1, "R9 set wins over clear");
        wr(2'd2, 32'h1);
        rd(2'd2, 32'h0, "R9 cleared after collision");

        idle(3);
        chk("R1 queue drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule